// File: doc/BRIEF.md
# Hashed Route Cache with Bank Swap

This block keeps recent forwarding decisions for IPv4 destinations in a direct-mapped cache. A destination is hashed to a cache slot. The slot holds a 32-bit destination tag, a 64-bit route word (the outbound interface and link-layer data) and a valid bit. A lookup returns either a hit with the route, or a miss. On a miss the surrounding logic runs a full-table search and then writes the answer back through the fill port.

The block also holds the forwarding table in two equal banks. The active bank is read through a table read port. A management write port rewrites only the other bank. Pulsing the swap input exchanges the two roles and invalidates the whole cache. The invalidation is a sweep that clears one slot per clock. While the sweep runs, a busy flag blocks lookups and fills. Reset starts the same sweep, so no valid bits need a reset of their own.

Top module: `route_cache`

## Requirements
- R1: The cache slot index is dst[9:0] XOR dst[19:10] (with the default IDX_W of 10). Two destinations with the same index share one slot, so filling one of them evicts the other.
- R2: A lookup accepted at a clock edge raises rsp_valid for exactly one cycle, on the second edge after it. With no accepted lookup, rsp_valid and rsp_hit are both 0.
- R3: A response is a hit only if the slot is valid and its stored 32-bit tag equals the looked-up destination. On a miss, rsp_route is all zeros.
- R4: A fill that is accepted installs the tag and route and marks the slot valid at that edge. A lookup accepted at the same edge already sees the new entry.
- R5: swap_req toggles act_bank at the next edge and raises lk_busy at that edge.
- R6: lk_busy stays high for exactly 2**IDX_W cycles after the last reset edge or swap edge. Once it falls, every slot is invalid.
- R7: Lookups and fills presented while lk_busy is high, or in the same cycle as swap_req, are ignored: a lookup gets no response and a fill installs nothing.
- R8: A management write goes to the bank that is not active. The word becomes readable through the table read port only after a swap.
- R9: The table read port returns the active bank's word at tb_addr one cycle after the address is presented, using the bank that was active at that edge.
- R10: Synchronous reset sets act_bank to 0, clears rsp_valid and raises lk_busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_req | input | 1 | Lookup request |
| lk_dst | input | 32 | Destination address to look up |
| lk_busy | output | 1 | Invalidation sweep in progress |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_hit | output | 1 | Response is a hit |
| rsp_route | output | 64 | Cached route word on a hit, zero on a miss |
| fill_en | input | 1 | Install an entry |
| fill_dst | input | 32 | Destination tag to install |
| fill_route | input | 64 | Route word to install |
| swap_req | input | 1 | Swap table banks and invalidate the cache |
| act_bank | output | 1 | Index of the active table bank |
| mg_we | input | 1 | Management write to the inactive bank |
| mg_addr | input | TBL_AW | Management write address |
| mg_data | input | 64 | Management write data |
| tb_addr | input | TBL_AW | Table read address (active bank) |
| tb_data | output | 64 | Table read data, one cycle later |

## Verification
A lookup response is due two edges after its request is accepted. A table read word is due one edge after its address is presented. The bank flag and the busy flag change on the edge that follows a swap, and the busy flag falls 2**IDX_W edges later.

The bench drives its inputs at the falling edge. Its behavioural model advances once per rising edge. That model evaluates the response stage against the cache state from before that edge, and applies fills and swaps afterwards. All outputs are compared against the model at the next falling edge. Directed checks wait exactly those numbers of edges before they sample.

// File: rtl/rc_pkg.sv
package rc_pkg;
    localparam int ADDR_W  = 32;
    localparam int ROUTE_W = 64;

    typedef logic [ADDR_W-1:0]  addr_t;
    typedef logic [ROUTE_W-1:0] route_t;

    typedef struct packed {
        logic  vld;
        addr_t dst;
    } lkup_t;

    typedef struct packed {
        logic   vld;
        logic   hit;
        route_t route;
    } resp_t;

    typedef struct packed {
        addr_t  tag;
        route_t route;
    } entry_t;
endpackage

// File: rtl/rc_sweep.sv
module rc_sweep #(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             swap_req,
    output logic             busy,
    output logic             clr_en,
    output logic [IDX_W-1:0] clr_idx,
    output logic             bank
);
    localparam logic [IDX_W-1:0] LAST = '1;

    logic [IDX_W-1:0] ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b1;
            ptr  <= '0;
            bank <= 1'b0;
        end else if (swap_req) begin
            busy <= 1'b1;
            ptr  <= '0;
            bank <= ~bank;
        end else if (busy) begin
            ptr <= ptr + 1'b1;
            if (ptr == LAST) busy <= 1'b0;
        end
    end

    assign clr_en  = busy;
    assign clr_idx = ptr;
endmodule

// File: rtl/rc_store.sv
module rc_store
    import rc_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lk_accept,
    input  addr_t            lk_dst,
    input  logic             fill_we,
    input  addr_t            fill_dst,
    input  route_t           fill_route,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    output resp_t            resp
);
    localparam int DEPTH = 1 << IDX_W;

    function automatic logic [IDX_W-1:0] slot_of(input addr_t a);
        return a[IDX_W-1:0] ^ a[2*IDX_W-1:IDX_W];
    endfunction

    logic [DEPTH-1:0] vld;
    entry_t           mem [DEPTH];
    lkup_t            s1;
    logic [IDX_W-1:0] fidx, ridx;
    logic             hit_c;

    assign fidx  = slot_of(fill_dst);
    assign ridx  = slot_of(s1.dst);
    assign hit_c = s1.vld && vld[ridx] && (mem[ridx].tag == s1.dst);

    always_ff @(posedge clk) begin
        if (clr_en)       vld[clr_idx] <= 1'b0;
        else if (fill_we) vld[fidx]    <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (fill_we) mem[fidx] <= '{tag: fill_dst, route: fill_route};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1   <= '0;
            resp <= '0;
        end else begin
            s1         <= '{vld: lk_accept, dst: lk_dst};
            resp.vld   <= s1.vld;
            resp.hit   <= hit_c;
            resp.route <= hit_c ? mem[ridx].route : '0;
        end
    end
endmodule

// File: rtl/rc_table.sv
module rc_table
    import rc_pkg::*;
#(
    parameter int TBL_AW = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bank,
    input  logic              we,
    input  logic [TBL_AW-1:0] waddr,
    input  route_t            wdata,
    input  logic [TBL_AW-1:0] raddr,
    output route_t            rdata
);
    localparam int DEPTH = 1 << TBL_AW;

    route_t rd_b [2];
    logic   bank_q;

    for (genvar b = 0; b < 2; b++) begin : g_bank
        route_t store [DEPTH];
        always_ff @(posedge clk) begin
            if (we && (bank != 1'(b))) store[waddr] <= wdata;
            rd_b[b] <= store[raddr];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) bank_q <= 1'b0;
        else     bank_q <= bank;
    end

    assign rdata = rd_b[bank_q];
endmodule

// File: rtl/route_cache.sv
module route_cache
    import rc_pkg::*;
#(
    parameter int IDX_W  = 10,
    parameter int TBL_AW = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_req,
    input  logic [31:0]       lk_dst,
    output logic              lk_busy,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [63:0]       rsp_route,
    input  logic              fill_en,
    input  logic [31:0]       fill_dst,
    input  logic [63:0]       fill_route,
    input  logic              swap_req,
    output logic              act_bank,
    input  logic              mg_we,
    input  logic [TBL_AW-1:0] mg_addr,
    input  logic [63:0]       mg_data,
    input  logic [TBL_AW-1:0] tb_addr,
    output logic [63:0]       tb_data
);
    logic             busy, clr_en, accept, fill_we;
    logic [IDX_W-1:0] clr_idx;
    resp_t            resp;

    assign accept  = lk_req  && !busy && !swap_req;
    assign fill_we = fill_en && !busy && !swap_req;

    rc_sweep #(.IDX_W(IDX_W)) u_sweep (
        .clk(clk), .rst(rst), .swap_req(swap_req), .busy(busy),
        .clr_en(clr_en), .clr_idx(clr_idx), .bank(act_bank)
    );

    rc_store #(.IDX_W(IDX_W)) u_store (
        .clk(clk), .rst(rst), .lk_accept(accept), .lk_dst(lk_dst),
        .fill_we(fill_we), .fill_dst(fill_dst), .fill_route(fill_route),
        .clr_en(clr_en), .clr_idx(clr_idx), .resp(resp)
    );

    rc_table #(.TBL_AW(TBL_AW)) u_table (
        .clk(clk), .rst(rst), .bank(act_bank), .we(mg_we), .waddr(mg_addr),
        .wdata(mg_data), .raddr(tb_addr), .rdata(tb_data)
    );

    assign lk_busy   = busy;
    assign rsp_valid = resp.vld;
    assign rsp_hit   = resp.hit;
    assign rsp_route = resp.route;
endmodule

// File: rtl/rc_checker.sv
module rc_checker #(
    parameter int IDX_W = 10
) (
    input logic        clk,
    input logic        rst,
    input logic        lk_req,
    input logic        lk_busy,
    input logic        swap_req,
    input logic        rsp_valid,
    input logic        rsp_hit,
    input logic [63:0] rsp_route,
    input logic        act_bank
);
    localparam int DEPTH = 1 << IDX_W;

    int busy_cnt;

    always_ff @(posedge clk) begin
        if (rst || swap_req) busy_cnt <= 0;
        else if (lk_busy)    busy_cnt <= busy_cnt + 1;
    end

    p_swap_busy_r5: assert property (@(posedge clk) disable iff (rst)
        swap_req |=> lk_busy);

    p_swap_toggle_r5: assert property (@(posedge clk) disable iff (rst)
        swap_req |=> (act_bank != $past(act_bank)));

    p_bank_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !swap_req |=> $stable(act_bank));

    p_rsp_origin_r2: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(lk_req && !lk_busy && !swap_req, 2));

    p_rsp_due_r2: assert property (@(posedge clk) disable iff (rst)
        (lk_req && !lk_busy && !swap_req) |=> ##1 rsp_valid);

    p_idle_nohit_r2: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> !rsp_hit);

    p_miss_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> (rsp_route == 64'd0));

    p_sweep_len_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(lk_busy) |-> (busy_cnt == DEPTH));

    p_busy_drop_r7: assert property (@(posedge clk) disable iff (rst)
        (lk_busy && lk_req) |=> ##1 !rsp_valid);
endmodule

bind route_cache rc_checker #(.IDX_W(IDX_W)) i_rc_checker (
    .clk(clk), .rst(rst), .lk_req(lk_req), .lk_busy(lk_busy),
    .swap_req(swap_req), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_route(rsp_route), .act_bank(act_bank)
);

// File: tb/test_route_cache.sv
`timescale 1ns/1ps
module test_route_cache;
    localparam int IDX_W  = 10;
    localparam int TBL_AW = 6;
    localparam int DEPTH  = 1 << IDX_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              lk_req = 1'b0, fill_en = 1'b0, swap_req = 1'b0, mg_we = 1'b0;
    logic [31:0]       lk_dst = '0, fill_dst = '0;
    logic [63:0]       fill_route = '0, mg_data = '0;
    logic [TBL_AW-1:0] mg_addr = '0, tb_addr = '0;
    logic              lk_busy, rsp_valid, rsp_hit, act_bank;
    logic [63:0]       rsp_route, tb_data;

    int n_tests = 0, n_fail = 0, cycles = 0;
    bit done = 1'b0;

    route_cache #(.IDX_W(IDX_W), .TBL_AW(TBL_AW)) i_route_cache (.*);

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Behavioural reference model
    bit          m_vld [int];
    logic [31:0] m_tag [int];
    logic [63:0] m_rte [int];
    logic [63:0] m_tbl0 [int];
    logic [63:0] m_tbl1 [int];
    int          m_busy = DEPTH;
    bit          m_bank = 0;
    bit          s1_v = 0;
    logic [31:0] s1_dst;
    bit          e_v = 0, e_hit = 0, e_tbk = 0;
    logic [63:0] e_rte = '0, e_tb = '0;

    function automatic int slot(input logic [31:0] d);
        return int'(d[9:0] ^ d[19:10]);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_vld.delete(); m_busy = DEPTH; m_bank = 0;
            s1_v = 0; e_v = 0; e_hit = 0; e_rte = '0; e_tbk = 0;
        end else begin
            int i;
            e_v = s1_v; e_hit = 0; e_rte = '0;
            if (s1_v) begin
                i = slot(s1_dst);
                if (m_vld.exists(i) && m_tag[i] == s1_dst) begin
                    e_hit = 1; e_rte = m_rte[i];
                end
            end
            s1_v   = lk_req && m_busy == 0 && !swap_req;
            s1_dst = lk_dst;
            if (m_bank) begin
                e_tbk = m_tbl1.exists(int'(tb_addr));
                if (e_tbk) e_tb = m_tbl1[int'(tb_addr)];
                if (mg_we) m_tbl0[int'(mg_addr)] = mg_data;
            end else begin
                e_tbk = m_tbl0.exists(int'(tb_addr));
                if (e_tbk) e_tb = m_tbl0[int'(tb_addr)];
                if (mg_we) m_tbl1[int'(mg_addr)] = mg_data;
            end
            if (fill_en && m_busy == 0 && !swap_req) begin
                i = slot(fill_dst);
                m_vld[i] = 1; m_tag[i] = fill_dst; m_rte[i] = fill_route;
            end
            if (swap_req) begin
                m_busy = DEPTH; m_bank = !m_bank; m_vld.delete();
            end else if (m_busy > 0) m_busy--;
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R2 rsp_valid", 64'(rsp_valid), 64'(e_v));
            if (e_v) begin
                chk("R3 rsp_hit", 64'(rsp_hit), 64'(e_hit));
                chk("R3 rsp_route", rsp_route, e_rte);
            end
            chk("R6 lk_busy", 64'(lk_busy), 64'(m_busy > 0));
            chk("R5 act_bank", 64'(act_bank), 64'(m_bank));
            if (e_tbk) chk("R9 tb_data", tb_data, e_tb);
        end
    end

    task automatic lookup(input logic [31:0] d);
        lk_req = 1'b1; lk_dst = d;
        @(negedge clk); lk_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic fill(input logic [31:0] d, input logic [63:0] r);
        fill_en = 1'b1; fill_dst = d; fill_route = r;
        @(negedge clk); fill_en = 1'b0;
    endtask

    task automatic swap();
        swap_req = 1'b1;
        @(negedge clk); swap_req = 1'b0;
    endtask

    task automatic wait_idle();
        while (lk_busy) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    localparam logic [31:0] D1 = 32'h0A01_0203;
    localparam logic [31:0] D2 = D1 ^ 32'h0000_0401; // same slot, other tag
    localparam logic [31:0] D3 = 32'hC0A8_7711;
    localparam logic [31:0] D4 = 32'h0B0C_0D0E;

    initial begin
        @(negedge clk); @(negedge clk); @(negedge clk);
        // R10 reset state
        chk("R10 rsp_valid", 64'(rsp_valid), 64'd0);
        chk("R10 lk_busy", 64'(lk_busy), 64'd1);
        chk("R10 act_bank", 64'(act_bank), 64'd0);
        rst = 1'b0;
        wait_idle();

        lookup(D1);
        chk("R3 cold miss", 64'(rsp_hit), 64'd0);
        fill(D1, 64'h1111_2222_3333_4444);
        lookup(D1);
        chk("R4 hit after fill", rsp_route, 64'h1111_2222_3333_4444);

        lookup(D2);
        chk("R1 alias tag mismatch", 64'(rsp_hit), 64'd0);
        fill(D2, 64'hAAAA_0000_BBBB_0001);
        lookup(D1);
        chk("R1 alias evicted", 64'(rsp_hit), 64'd0);
        lookup(D2);
        chk("R1 alias resident", 64'(rsp_hit), 64'd1);

        // R4 same-cycle fill and lookup
        lk_req = 1'b1; lk_dst = D3;
        fill_en = 1'b1; fill_dst = D3; fill_route = 64'h5555_6666_7777_8888;
        @(negedge clk); lk_req = 1'b0; fill_en = 1'b0;
        @(negedge clk);
        chk("R4 same-cycle fill", 64'(rsp_hit), 64'd1);

        // back-to-back lookups, one per cycle
        for (int k = 0; k < 8; k++) begin
            lk_req = 1'b1; lk_dst = (k % 2 == 0) ? D2 : D3 + 32'(k);
            @(negedge clk);
        end
        lk_req = 1'b0;
        @(negedge clk); @(negedge clk);

        // R8 management write lands in the inactive bank
        mg_we = 1'b1; mg_addr = 6'd5; mg_data = 64'hFEED_0000_0000_0005;
        @(negedge clk); mg_we = 1'b0;
        swap();
        tb_addr = 6'd5;
        @(negedge clk);
        chk("R8 visible after swap", tb_data, 64'hFEED_0000_0000_0005);
        mg_we = 1'b1; mg_data = 64'hBEEF_0000_0000_0005;
        @(negedge clk); mg_we = 1'b0;
        @(negedge clk);
        chk("R8 active bank untouched", tb_data, 64'hFEED_0000_0000_0005);

        // R7 lookup and fill during sweep are ignored
        lk_req = 1'b1; lk_dst = D2;
        fill_en = 1'b1; fill_dst = D4; fill_route = 64'h4444;
        @(negedge clk); lk_req = 1'b0; fill_en = 1'b0;
        @(negedge clk);
        chk("R7 no response while busy", 64'(rsp_valid), 64'd0);
        wait_idle();
        lookup(D4);
        chk("R7 busy fill dropped", 64'(rsp_hit), 64'd0);
        lookup(D2);
        chk("R6 cache invalidated", 64'(rsp_hit), 64'd0);

        swap();
        @(negedge clk);
        chk("R8 second swap shows new word", tb_data, 64'hBEEF_0000_0000_0005);
        repeat (10) @(negedge clk);
        swap(); // restart sweep mid-way
        wait_idle();

        // R7 lookup in same cycle as swap is dropped
        fill(D3, 64'h9);
        swap_req = 1'b1; lk_req = 1'b1; lk_dst = D3;
        @(negedge clk); swap_req = 1'b0; lk_req = 1'b0;
        @(negedge clk);
        chk("R7 swap-cycle lookup dropped", 64'(rsp_valid), 64'd0);
        wait_idle();
        @(negedge clk);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule